// File: doc/BRIEF.md
# Banked register write unit

This block holds the mode-banked registers of a multi-mode 32-bit processor. It handles the decoded form of a move-to-banked-register operation. The request carries a 5-bit selector, a flag that picks the saved-status space, the index of the source register, the 32-bit value, the current processor mode, and a flag saying whether the highest privilege level runs the 32-bit architecture. From these the block writes one of three kinds of target: a banked copy of R8 to R14, the saved status word of an exception mode, or the hypervisor exception return address.

Some requests are not allowed. These are a source index of 15, a request made in User mode, and a selector with no mapping. Each of these raises a one-cycle error pulse and leaves all storage unchanged. A request that names a Monitor-mode target while the top privilege level is not 32-bit raises a one-cycle trap pulse instead of writing. A combinational read port takes the same selector and flag, so the stored contents can be checked.

Top module: `bkw_unit`

## Requirements
- R1: While rst_ni is low, every stored word clears to zero and err_o and trap_o are 0.
- R2: With the saved-status flag at 1, these selector values reach a saved status word, and no other selector does: 14 FIQ, 16 IRQ, 18 Supervisor, 20 Abort, 22 Undefined, 28 Monitor, 30 Hyp.
- R3: With the flag at 0, selectors 0 to 6 reach User-mode R8 to R14 (register = selector + 8), and selectors 8 to 14 reach FIQ-mode R8 to R14 (register = selector[2:0] + 8). Selectors 7 and 15 are unmapped.
- R4: With the flag at 0, selector pairs 16/17, 18/19, 20/21, 22/23 and 28/29 reach the IRQ, Supervisor, Abort, Undefined and Monitor registers. The even value of each pair selects LR and the odd value selects SP.
- R5: With the flag at 0, selector 30 reaches the hypervisor exception link register and selector 31 reaches the Hyp-mode SP.
- R6: A valid request to an unmapped selector (flag 0: 7, 15, 24 to 27; flag 1: any value not listed in R2) raises err_o and writes nothing.
- R7: A valid request with source index 15 raises err_o and writes nothing.
- R8: A valid request while cur_mode_i equals User (5'b10000) raises err_o and writes nothing.
- R9: A Monitor target is selector 28 or 29 with the flag at 0, or selector 28 with the flag at 1. A valid request to a Monitor target with top_el_32_i low raises trap_o and writes nothing. If the request is also an error case, err_o is raised and trap_o is not.
- R10: A legal request is stored at the next rising clock edge. err_o and trap_o go high in the cycle after the request and stay high for that one cycle only. Requests may arrive on back-to-back cycles.
- R11: While req_valid_i is low, nothing is stored and no pulse is raised.
- R12: The read port returns rd_hit_o=1 and the stored word for every mapped address. For an unmapped address it returns rd_hit_o=0 and data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_sel_i | input | 5 | Target selector |
| req_spsr_i | input | 1 | Selects the saved-status space |
| req_src_idx_i | input | 4 | Source register index |
| req_data_i | input | DATA_W | Value to store |
| cur_mode_i | input | 5 | Current processor mode |
| top_el_32_i | input | 1 | Highest privilege level runs the 32-bit architecture |
| rd_sel_i | input | 5 | Read selector |
| rd_spsr_i | input | 1 | Read saved-status flag |
| rd_data_o | output | DATA_W | Stored word at the read address |
| rd_hit_o | output | 1 | Read address is mapped |
| trap_o | output | 1 | Monitor trap pulse |
| err_o | output | 1 | Unpredictable-access error pulse |

## Verification
The bench uses the default DATA_W of 32. The whole address space is only 64 selector/flag combinations, so every combination is written and then read back through the read port. After each operation, all 64 read addresses are compared against a model, which shows that each write lands in its own slot and disturbs no other. The sweep is repeated with the top privilege level marked as not 32-bit, which covers every Monitor trap. Targeted requests then cover source index 15, User mode, error-over-trap priority, idle cycles and back-to-back requests.

// File: rtl/bkw_pkg.sv
package bkw_pkg;
  localparam int unsigned SEL_W  = 5;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned MODE_W = 5;
  localparam int unsigned NSLOT  = 33;
  localparam int unsigned SLOT_W = $clog2(NSLOT);

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;

  // slot layout
  localparam int unsigned S_USR = 0;   // usr r8..r14
  localparam int unsigned S_FIQ = 7;   // fiq r8..r14
  localparam int unsigned S_EXC = 14;  // irq/svc/abt/und lr,sp pairs
  localparam int unsigned S_MON = 22;  // mon lr,sp
  localparam int unsigned S_ELR = 24;  // hyp elr, hyp sp at +1
  localparam int unsigned S_PSR = 26;  // fiq,irq,svc,abt,und,mon,hyp

  typedef struct packed {
    logic              hit;
    logic              mon;
    logic [SLOT_W-1:0] slot;
  } dec_t;
endpackage

// File: rtl/bkw_decode.sv
module bkw_decode
  import bkw_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  logic             spsr_i,
  output dec_t             dec_o
);
  always_comb begin
    dec_o = '0;
    if (spsr_i) begin
      dec_o.hit = 1'b1;
      case (sel_i)
        5'b01110: dec_o.slot = SLOT_W'(S_PSR + 0);
        5'b10000: dec_o.slot = SLOT_W'(S_PSR + 1);
        5'b10010: dec_o.slot = SLOT_W'(S_PSR + 2);
        5'b10100: dec_o.slot = SLOT_W'(S_PSR + 3);
        5'b10110: dec_o.slot = SLOT_W'(S_PSR + 4);
        5'b11100: begin
          dec_o.slot = SLOT_W'(S_PSR + 5);
          dec_o.mon  = 1'b1;
        end
        5'b11110: dec_o.slot = SLOT_W'(S_PSR + 6);
        default:  dec_o.hit  = 1'b0;
      endcase
    end else if (!sel_i[4]) begin
      // r15 is not banked
      if (sel_i[2:0] != 3'b111) begin
        dec_o.hit  = 1'b1;
        dec_o.slot = SLOT_W'((sel_i[3] ? S_FIQ : S_USR) + 32'(sel_i[2:0]));
      end
    end else begin
      case (sel_i[3:1])
        3'b000, 3'b001, 3'b010, 3'b011: begin
          dec_o.hit  = 1'b1;
          dec_o.slot = SLOT_W'(S_EXC + 32'(sel_i[2:0]));
        end
        3'b110: begin
          dec_o.hit  = 1'b1;
          dec_o.mon  = 1'b1;
          dec_o.slot = SLOT_W'(S_MON + 32'(sel_i[0]));
        end
        3'b111: begin
          dec_o.hit  = 1'b1;
          dec_o.slot = SLOT_W'(S_ELR + 32'(sel_i[0]));
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bkw_gate.sv
module bkw_gate
  import bkw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [IDX_W-1:0]  src_idx_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              top_el_32_i,
  input  dec_t              dec_i,
  output logic              we_o,
  output logic              trap_o,
  output logic              err_o
);
  logic bad, trap_c;

  // unpredictable cases win over the monitor trap
  assign bad    = (src_idx_i == {IDX_W{1'b1}}) || (mode_i == MODE_USR) || !dec_i.hit;
  assign trap_c = !bad && dec_i.mon && !top_el_32_i;
  assign we_o   = valid_i && !bad && !trap_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o  <= 1'b0;
      trap_o <= 1'b0;
    end else begin
      err_o  <= valid_i && bad;
      trap_o <= valid_i && trap_c;
    end
  end
endmodule

// File: rtl/bkw_bank.sv
module bkw_bank
  import bkw_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [SLOT_W-1:0]       wslot_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic                    rhit_i,
  input  logic [SLOT_W-1:0]       rslot_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic [NSLOT*DATA_W-1:0] bank_o
);
  logic [DATA_W-1:0] mem_q [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[g] <= '0;
      else if (we_i && wslot_i == SLOT_W'(g))      mem_q[g] <= wdata_i;
    end
    assign bank_o[g*DATA_W +: DATA_W] = mem_q[g];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NSLOT; i++)
      if (rhit_i && rslot_i == SLOT_W'(i)) rdata_o = mem_q[i];
  end
endmodule

// File: rtl/bkw_unit.sv
module bkw_unit
  import bkw_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [SEL_W-1:0]  req_sel_i,
  input  logic              req_spsr_i,
  input  logic [IDX_W-1:0]  req_src_idx_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic [MODE_W-1:0] cur_mode_i,
  input  logic              top_el_32_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  input  logic              rd_spsr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_hit_o,
  output logic              trap_o,
  output logic              err_o
);
  dec_t                    wdec, rdec;
  logic                    we;
  logic [NSLOT*DATA_W-1:0] bank_flat;

  bkw_decode u_wdec (.sel_i(req_sel_i), .spsr_i(req_spsr_i), .dec_o(wdec));
  bkw_decode u_rdec (.sel_i(rd_sel_i),  .spsr_i(rd_spsr_i),  .dec_o(rdec));

  bkw_gate u_gate (
    .clk_i, .rst_ni,
    .valid_i     (req_valid_i),
    .src_idx_i   (req_src_idx_i),
    .mode_i      (cur_mode_i),
    .top_el_32_i (top_el_32_i),
    .dec_i       (wdec),
    .we_o        (we),
    .trap_o      (trap_o),
    .err_o       (err_o)
  );

  bkw_bank #(.DATA_W(DATA_W)) u_bank (
    .clk_i, .rst_ni,
    .we_i    (we),
    .wslot_i (wdec.slot),
    .wdata_i (req_data_i),
    .rhit_i  (rdec.hit),
    .rslot_i (rdec.slot),
    .rdata_o (rd_data_o),
    .bank_o  (bank_flat)
  );

  assign rd_hit_o = rdec.hit;
endmodule

// File: rtl/bkw_unit_sva.sv
module bkw_unit_sva
  import bkw_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_valid_i,
  input logic [IDX_W-1:0]        req_src_idx_i,
  input logic [MODE_W-1:0]       cur_mode_i,
  input logic                    top_el_32_i,
  input logic                    trap_o,
  input logic                    err_o,
  input logic [NSLOT*DATA_W-1:0] bank_flat
);
  a_r9_err_beats_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_o && trap_o));

  a_r9_trap_only_non32_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> ($past(req_valid_i) && !$past(top_el_32_i)));

  a_r10_err_from_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_valid_i));

  a_r7_src15_errs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_valid_i && req_src_idx_i == {IDX_W{1'b1}}) |-> err_o);

  a_r8_user_mode_errs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_valid_i && cur_mode_i == MODE_USR) |-> err_o);

  a_r11_idle_holds_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_valid_i) |-> $stable(bank_flat));

  a_r6_fault_holds_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o || trap_o) |-> $stable(bank_flat));
endmodule

bind bkw_unit bkw_unit_sva #(.DATA_W(DATA_W)) u_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_src_idx_i (req_src_idx_i),
  .cur_mode_i    (cur_mode_i),
  .top_el_32_i   (top_el_32_i),
  .trap_o        (trap_o),
  .err_o         (err_o),
  .bank_flat     (bank_flat)
);

// File: tb/sim_bkw_unit.sv
`timescale 1ns/1ps
module sim_bkw_unit;
  localparam logic [4:0] MD_USR = 5'b10000;
  localparam logic [4:0] MD_SVC = 5'b10011;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_spsr_i = 1'b0, top_el_32_i = 1'b1;
  logic [4:0]  req_sel_i = '0, cur_mode_i = MD_SVC, rd_sel_i = '0;
  logic [3:0]  req_src_idx_i = '0;
  logic [31:0] req_data_i = '0;
  logic        rd_spsr_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        rd_hit_o, trap_o, err_o;

  int checks = 0, fails = 0;
  logic [31:0] mdl [64];

  always #2 clk_i = ~clk_i;

  bkw_unit u0 (.*);

  function automatic bit exp_hit(int a);
    int s = a % 32;
    if (a >= 32) return s == 14 || s == 16 || s == 18 || s == 20 || s == 22 || s == 28 || s == 30;
    if (s < 16) return (s % 8) != 7;
    return !(s >= 24 && s <= 27);
  endfunction

  function automatic bit exp_mon(int a);
    int s = a % 32;
    return (a >= 32) ? (s == 28) : (s == 28 || s == 29);
  endfunction

  function automatic string tag_of(int a);
    int s = a % 32;
    if (!exp_hit(a)) return (a < 32 && s < 16) ? "R3" : "R6";
    if (a >= 32) return "R2";
    if (s < 16) return "R3";
    if (s >= 30) return "R5";
    return "R4";
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic sweep(string r);
    for (int a = 0; a < 64; a++) begin
      rd_sel_i  = 5'(a % 32);
      rd_spsr_i = (a >= 32);
      #0.01;
      chk(r, 32'(rd_hit_o), 32'(exp_hit(a)));
      chk(r, rd_data_o, exp_hit(a) ? mdl[a] : 32'h0);
    end
  endtask

  // call just after a negedge; returns after the next two negedges
  task automatic send(int a, int idx, logic [31:0] d, logic [4:0] md, bit e32, string r);
    bit bad, tr;
    bad = (idx == 15) || (md == MD_USR) || !exp_hit(a);
    tr  = !bad && exp_mon(a) && !e32;
    req_sel_i = 5'(a % 32); req_spsr_i = (a >= 32); req_src_idx_i = 4'(idx);
    req_data_i = d; cur_mode_i = md; top_el_32_i = e32; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (!bad && !tr) mdl[a] = d;
    chk(r, 32'(err_o), 32'(bad));
    chk(r, 32'(trap_o), 32'(tr));
    @(negedge clk_i);
    chk("R10", 32'(err_o), 0);
    chk("R10", 32'(trap_o), 0);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < 64; a++) mdl[a] = '0;
    req_data_i = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk_i);
    // R1: cleared during reset
    chk("R1", 32'(err_o), 0);
    chk("R1", 32'(trap_o), 0);
    sweep("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    sweep("R12");

    // R2..R6 full selector sweep, legal mode, 32-bit top
    for (int a = 0; a < 64; a++) begin
      send(a, a % 15, 32'hC0DE_0000 ^ (32'(a) * 32'h0101_0101), MD_SVC, 1'b1, tag_of(a));
      sweep(tag_of(a));
    end

    // R9: non-32-bit top traps monitor targets only
    for (int a = 0; a < 64; a++) begin
      send(a, 2, 32'h5A00_0000 + 32'(a), MD_SVC, 1'b0, exp_mon(a) ? "R9" : tag_of(a));
      sweep("R9");
    end
    send(29, 15, 32'hDEAD_0001, MD_SVC, 1'b0, "R9");
    send(60, 3, 32'hDEAD_0002, MD_USR, 1'b0, "R9");
    sweep("R9");

    // R7 / R8
    send(3, 15, 32'hBAD0_0007, MD_SVC, 1'b1, "R7");
    send(46, 0, 32'hBAD0_0008, MD_USR, 1'b1, "R8");
    sweep("R7");

    // R11: idle cycle with busy data bus
    req_sel_i = 5'd4; req_spsr_i = 1'b0; req_src_idx_i = 4'd1;
    req_data_i = 32'h1111_2222; cur_mode_i = MD_SVC; top_el_32_i = 1'b1;
    @(negedge clk_i);
    chk("R11", 32'(err_o), 0);
    chk("R11", 32'(trap_o), 0);
    sweep("R11");

    // R10: back-to-back, unmapped then mapped
    req_valid_i = 1'b1; req_sel_i = 5'd25; req_data_i = 32'h7777_0001;
    @(negedge clk_i);
    chk("R10", 32'(err_o), 1);
    req_sel_i = 5'd17; req_data_i = 32'h7777_0002;
    @(negedge clk_i);
    chk("R10", 32'(err_o), 0);
    mdl[17] = 32'h7777_0002;
    req_sel_i = 5'd18; req_data_i = 32'h7777_0003;
    @(negedge clk_i);
    mdl[18] = 32'h7777_0003;
    req_valid_i = 1'b0;
    chk("R10", 32'(err_o), 0);
    sweep("R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule